// File: doc/BRIEF.md
# Sleep-State Wakeup Sequencer

This block supervises the deepest power-saving state of a small controller. While the CPU runs, a sleep request parks the block in its sleep state and stores the CPU priority level present at that moment. The block then watches a set of wakeup sources:
- a number of external pins, each with its own edge choice;
- serial receive lines that can be switched in as extra triggers;
- a periodic tick;
- a real-time alarm;
- an active-low non-maskable pin, which passes through a spike filter.

When a source fires, the block picks what happens next. The choices are a single transfer request followed by a return to sleep, standard idle, or full run. Before any of these, it waits for the clock system to report ready.

The CPU, the transfer engine, the real-time counter and the clock generator are outside the block. All inputs are taken as synchronous to `clk`.

Sources are indexed in this order: external pins 0..N_EXT-1, then serial lines N_EXT..N_EXT+N_SER-1, then the tick at N_EXT+N_SER, then the alarm at N_EXT+N_SER+1. The per-source vectors `src_ien`, `src_xfer_en` and `src_prio` use the same index. `src_prio` packs source i at bits [i*PRIO_W +: PRIO_W].

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset the state code is 0 (run), `cpu_run` is 1 and `xfer_req` is 0. State codes are: 0 run, 1 sleep, 2 clock wait, 3 transfer, 4 idle.
- R2: In run, a `sleep_req` high at a clock edge moves the block to sleep on that edge, and `cpu_run` drops. In sleep, any activity that is not a qualified trigger leaves the block in sleep.
- R3: External pin i uses the field `ext_edge[2i+1:2i]`. Bit 2i enables a rising edge and bit 2i+1 enables a falling edge, so 00 means no trigger and 11 means both edges.
- R4: A level change on serial line j is a trigger only while `ser_alt_en[j]` is 1.
- R5: `tick_pulse` is a trigger only when `rtc_sleep_en` and `tick_en` are both 1. `rtc_alarm` is a trigger only when `rtc_sleep_en` and `rtc_en` are both 1.
- R6: A low pulse on `nmi_n` lasting NMI_REJECT cycles or fewer is ignored. A low level held for NMI_ACCEPT cycles always wakes the block. An accepted pulse leads to run, whatever the enables are and whatever other sources fire in the same cycle.
- R7: Every wakeup passes through clock wait. Clock wait lasts while `clk_ready` is 0, with `cpu_run` at 0.
- R8: The block takes the transfer path when all of these hold for the winning source: `gie` is 1, the source's `src_ien` is 1, the source's `src_xfer_en` is 1, and its priority is strictly above the stored CPU priority. On this path, `xfer_req` is high for exactly one cycle, in the first cycle of transfer, with `xfer_chan` giving the source index. A `xfer_done` in transfer returns the block to sleep on the next edge.
- R9: If the winning source's `src_ien` is 0, the block continues to idle. In idle, `idle_wake` moves it to run.
- R10: If the winning source's `src_ien` is 1 but the transfer conditions fail, the block continues to run.
- R11: Among sources firing in the same cycle, the highest `src_prio` wins. On equal priority, the higher source index wins.
- R12: The priority comparison uses `cpu_prio` as sampled at sleep entry. Changes to `cpu_prio` while asleep have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | CPU asks for sleep |
| cpu_prio | input | PRIO_W | Current CPU priority level |
| gie | input | 1 | Global interrupt enable |
| src_ien | input | N_SRC | Per-source interrupt enable |
| src_xfer_en | input | N_SRC | Per-source transfer enable |
| src_prio | input | N_SRC*PRIO_W | Per-source priority levels |
| ext_pin | input | N_EXT | External interrupt pins |
| ext_edge | input | 2*N_EXT | Edge select per pin (rise, fall) |
| ser_rx | input | N_SER | Serial receive lines |
| ser_alt_en | input | N_SER | Use receive line as trigger |
| rtc_sleep_en | input | 1 | Real-time logic kept running in sleep |
| tick_pulse | input | 1 | Periodic tick request |
| tick_en | input | 1 | Tick interrupt enable |
| rtc_alarm | input | 1 | Real-time alarm request |
| rtc_en | input | 1 | Alarm interrupt enable |
| nmi_n | input | 1 | Non-maskable pin, active low |
| clk_ready | input | 1 | Oscillator and PLL locked |
| xfer_done | input | 1 | Transfer engine finished |
| idle_wake | input | 1 | Leave idle for run |
| cpu_run | output | 1 | CPU may execute |
| xfer_req | output | 1 | One-cycle transfer request |
| xfer_chan | output | $clog2(N_SRC) | Source served by the transfer |
| ctl_state | output | 3 | State code |

## Verification
The bench runs a full sweep over every source, both enable flags, the transfer enable, and every pair of source and CPU priority. A design that used `>=` in the priority test would issue transfers at equal levels. A design that confused the two enables would send a disabled source to run instead of idle.

Directed cases cover the remaining corners:
- edge fields of 00, 01, 10 and 11, where a swapped bit wakes on the wrong edge;
- gated tick and alarm requests, where a missing term wakes the CPU without a running real-time block;
- a one-cycle spike, which a filter with too low a threshold would accept;
- a non-maskable pulse that arrives together with a transfer-qualified source, where a wrong order would start a transfer;
- two sources at equal and unequal priority, where a wrong tie-break gives the wrong `xfer_chan`;
- a CPU priority changed during sleep, which would flip the outcome if the level were not stored at entry.

// File: rtl/wk_pkg.sv
package wk_pkg;
   typedef enum logic [2:0] {
      ST_RUN     = 3'd0,
      ST_SLEEP   = 3'd1,
      ST_CLKWAIT = 3'd2,
      ST_XFER    = 3'd3,
      ST_IDLE    = 3'd4
   } wk_state_e;
endpackage

// File: rtl/wk_nmi_filter.sv
// Spike filter for the active-low non-maskable pin: a saturating count of
// consecutive low cycles; one event per low period once ACCEPT is reached.
module wk_nmi_filter #(
   parameter int REJECT = 2,
   parameter int ACCEPT = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_n,
   output logic nmi_evt
);
   localparam int CW = $clog2(ACCEPT + 1);

   if (ACCEPT <= REJECT || REJECT < 1) begin : g_bad_thresholds
      $error("wk_nmi_filter: need 1 <= REJECT < ACCEPT");
   end

   logic [CW-1:0] low_cnt;
   logic          evt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt <= '0;
         evt_q   <= 1'b0;
      end else begin
         evt_q <= !nmi_n && (low_cnt == CW'(ACCEPT - 1));
         if (nmi_n)
            low_cnt <= '0;
         else if (low_cnt != CW'(ACCEPT))
            low_cnt <= low_cnt + 1'b1;
      end
   end

   assign nmi_evt = evt_q;
endmodule

// File: rtl/wk_src_detect.sv
// Turns raw pins and requests into qualified per-source trigger hits.
module wk_src_detect #(
   parameter int N_EXT = 4,
   parameter int N_SER = 3,
   localparam int N_SRC = N_EXT + N_SER + 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_EXT-1:0]   ext_pin,
   input  logic [2*N_EXT-1:0] ext_edge,
   input  logic [N_SER-1:0]   ser_rx,
   input  logic [N_SER-1:0]   ser_alt_en,
   input  logic               rtc_sleep_en,
   input  logic               tick_pulse,
   input  logic               tick_en,
   input  logic               rtc_alarm,
   input  logic               rtc_en,
   output logic [N_SRC-1:0]   hit
);
   logic [N_EXT-1:0] ext_prev;
   logic [N_SER-1:0] ser_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_prev <= '0;
         ser_prev <= '0;
      end else begin
         ext_prev <= ext_pin;
         ser_prev <= ser_rx;
      end
   end

   for (genvar g = 0; g < N_EXT; g++) begin : g_ext
      assign hit[g] = (ext_edge[2*g]   &  ext_pin[g] & ~ext_prev[g])
                    | (ext_edge[2*g+1] & ~ext_pin[g] &  ext_prev[g]);
   end

   for (genvar g = 0; g < N_SER; g++) begin : g_ser
      assign hit[N_EXT+g] = ser_alt_en[g] & (ser_rx[g] ^ ser_prev[g]);
   end

   assign hit[N_EXT+N_SER]   = rtc_sleep_en & tick_en & tick_pulse;
   assign hit[N_EXT+N_SER+1] = rtc_sleep_en & rtc_en & rtc_alarm;
endmodule

// File: rtl/wk_arbiter.sv
// Highest priority level wins; equal levels go to the higher index.
module wk_arbiter #(
   parameter int N_SRC  = 9,
   parameter int PRIO_W = 4,
   localparam int SW = $clog2(N_SRC)
) (
   input  logic [N_SRC-1:0]        hit,
   input  logic [N_SRC*PRIO_W-1:0] src_prio,
   output logic                    any_hit,
   output logic [SW-1:0]           win_idx,
   output logic [PRIO_W-1:0]       win_prio
);
   always_comb begin
      any_hit  = 1'b0;
      win_idx  = '0;
      win_prio = '0;
      for (int i = 0; i < N_SRC; i++) begin
         if (hit[i] && (!any_hit || src_prio[i*PRIO_W +: PRIO_W] >= win_prio)) begin
            any_hit  = 1'b1;
            win_idx  = SW'(i);
            win_prio = src_prio[i*PRIO_W +: PRIO_W];
         end
      end
   end
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
   import wk_pkg::*;
#(
   parameter int N_EXT      = 4,
   parameter int N_SER      = 3,
   parameter int PRIO_W     = 4,
   parameter int NMI_REJECT = 2,
   parameter int NMI_ACCEPT = 6,
   localparam int N_SRC = N_EXT + N_SER + 2,
   localparam int SW    = $clog2(N_SRC)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sleep_req,
   input  logic [PRIO_W-1:0]       cpu_prio,
   input  logic                    gie,
   input  logic [N_SRC-1:0]        src_ien,
   input  logic [N_SRC-1:0]        src_xfer_en,
   input  logic [N_SRC*PRIO_W-1:0] src_prio,
   input  logic [N_EXT-1:0]        ext_pin,
   input  logic [2*N_EXT-1:0]      ext_edge,
   input  logic [N_SER-1:0]        ser_rx,
   input  logic [N_SER-1:0]        ser_alt_en,
   input  logic                    rtc_sleep_en,
   input  logic                    tick_pulse,
   input  logic                    tick_en,
   input  logic                    rtc_alarm,
   input  logic                    rtc_en,
   input  logic                    nmi_n,
   input  logic                    clk_ready,
   input  logic                    xfer_done,
   input  logic                    idle_wake,
   output logic                    cpu_run,
   output logic                    xfer_req,
   output logic [SW-1:0]           xfer_chan,
   output logic [2:0]              ctl_state
);
   if (N_EXT < 1 || N_SER < 1 || PRIO_W < 1) begin : g_bad_sizes
      $error("sleep_wake_ctrl: N_EXT, N_SER and PRIO_W must be at least 1");
   end

   logic [N_SRC-1:0]  hit;
   logic              nmi_evt, any_hit;
   logic [SW-1:0]     win_idx;
   logic [PRIO_W-1:0] win_prio;

   wk_nmi_filter #(.REJECT(NMI_REJECT), .ACCEPT(NMI_ACCEPT)) u_nmi (
      .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .nmi_evt(nmi_evt));

   wk_src_detect #(.N_EXT(N_EXT), .N_SER(N_SER)) u_det (
      .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_edge(ext_edge),
      .ser_rx(ser_rx), .ser_alt_en(ser_alt_en), .rtc_sleep_en(rtc_sleep_en),
      .tick_pulse(tick_pulse), .tick_en(tick_en), .rtc_alarm(rtc_alarm),
      .rtc_en(rtc_en), .hit(hit));

   wk_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
      .hit(hit), .src_prio(src_prio), .any_hit(any_hit),
      .win_idx(win_idx), .win_prio(win_prio));

   wk_state_e         state_q, state_d, path_q, wake_path;
   logic [SW-1:0]     chan_q;
   logic [PRIO_W-1:0] cprio_q;
   logic              xreq_q, xfer_ok;

   // continuation chosen for the winning source
   always_comb begin
      xfer_ok = gie && src_ien[win_idx] && src_xfer_en[win_idx] && (win_prio > cprio_q);
      if (xfer_ok)                wake_path = ST_XFER;
      else if (!src_ien[win_idx]) wake_path = ST_IDLE;
      else                        wake_path = ST_RUN;
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_RUN:     if (sleep_req) state_d = ST_SLEEP;
         ST_SLEEP:   if (nmi_evt || any_hit) state_d = ST_CLKWAIT;
         ST_CLKWAIT: if (clk_ready) state_d = path_q;
         ST_XFER:    if (xfer_done) state_d = ST_SLEEP;
         ST_IDLE:    if (idle_wake) state_d = ST_RUN;
         default:    state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         path_q  <= ST_RUN;
         chan_q  <= '0;
         cprio_q <= '0;
         xreq_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         xreq_q  <= (state_q == ST_CLKWAIT) && clk_ready && (path_q == ST_XFER);
         if (state_q == ST_RUN && sleep_req)
            cprio_q <= cpu_prio;
         if (state_q == ST_SLEEP) begin
            if (nmi_evt) begin
               path_q <= ST_RUN;
            end else if (any_hit) begin
               path_q <= wake_path;
               chan_q <= win_idx;
            end
         end
      end
   end

   assign cpu_run   = (state_q == ST_RUN);
   assign xfer_req  = xreq_q;
   assign xfer_chan = chan_q;
   assign ctl_state = state_q;
endmodule

// File: rtl/wk_checker.sv
module wk_checker
   import wk_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       sleep_req,
   input logic       clk_ready,
   input logic       xfer_done,
   input logic       idle_wake,
   input logic       cpu_run,
   input logic       xfer_req,
   input logic [2:0] ctl_state
);
   a_r2_enter_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_state == ST_RUN && sleep_req) |=> (ctl_state == ST_SLEEP && !cpu_run));

   a_r7_sleep_exit_via_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_state == ST_SLEEP) |=> (ctl_state == ST_SLEEP || ctl_state == ST_CLKWAIT));

   a_r7_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_state == ST_CLKWAIT && !clk_ready) |=> (ctl_state == ST_CLKWAIT && !cpu_run));

   a_r8_req_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req |-> (ctl_state == ST_XFER && $past(ctl_state) == ST_CLKWAIT));

   a_r8_req_single: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req |=> !xfer_req);

   a_r8_back_to_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_state == ST_XFER && xfer_done) |=> (ctl_state == ST_SLEEP));

   a_r9_idle_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_state == ST_IDLE && idle_wake) |=> cpu_run);
endmodule

bind sleep_wake_ctrl wk_checker u_chk (
   .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .clk_ready(clk_ready),
   .xfer_done(xfer_done), .idle_wake(idle_wake), .cpu_run(cpu_run),
   .xfer_req(xfer_req), .ctl_state(ctl_state));

// File: tb/sim_sleep_wake_ctrl.sv
`timescale 1ns/1ps
module sim_sleep_wake_ctrl;
   localparam int NE = 2, NR = 1, PW = 2, NS = NE + NR + 2, SW = $clog2(NS);
   localparam int ST_RUN = 0, ST_SLEEP = 1, ST_WAIT = 2, ST_XFER = 3, ST_IDLE = 4;

   logic clk = 0, rst_n = 0;
   logic sleep_req = 0, gie = 0, rtc_sleep_en = 1, tick_pulse = 0, tick_en = 1;
   logic rtc_alarm = 0, rtc_en = 1, nmi_n = 1, clk_ready = 0, xfer_done = 0, idle_wake = 0;
   logic [PW-1:0] cpu_prio = 0;
   logic [NS-1:0] src_ien = '1, src_xfer_en = '0;
   logic [NS*PW-1:0] src_prio = '0;
   logic [NE-1:0] ext_pin = 2'b10;
   logic [2*NE-1:0] ext_edge = 4'b1001;
   logic [NR-1:0] ser_rx = 0, ser_alt_en = 1;
   logic cpu_run, xfer_req;
   logic [SW-1:0] xfer_chan;
   logic [2:0] ctl_state;
   int n_run = 0, n_fail = 0;

   sleep_wake_ctrl #(.N_EXT(NE), .N_SER(NR), .PRIO_W(PW), .NMI_REJECT(1), .NMI_ACCEPT(3)) u0 (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .cpu_prio(cpu_prio), .gie(gie),
      .src_ien(src_ien), .src_xfer_en(src_xfer_en), .src_prio(src_prio),
      .ext_pin(ext_pin), .ext_edge(ext_edge), .ser_rx(ser_rx), .ser_alt_en(ser_alt_en),
      .rtc_sleep_en(rtc_sleep_en), .tick_pulse(tick_pulse), .tick_en(tick_en),
      .rtc_alarm(rtc_alarm), .rtc_en(rtc_en), .nmi_n(nmi_n), .clk_ready(clk_ready),
      .xfer_done(xfer_done), .idle_wake(idle_wake), .cpu_run(cpu_run),
      .xfer_req(xfer_req), .xfer_chan(xfer_chan), .ctl_state(ctl_state));

   always #10 clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic go_sleep(input int cp);
      cpu_prio = PW'(cp); sleep_req = 1; step(1); sleep_req = 0;
   endtask

   task automatic fire(input int src);
      case (src)
         0: begin ext_pin[0] = 1; step(1); ext_pin[0] = 0; end
         1: begin ext_pin[1] = 0; step(1); ext_pin[1] = 1; end
         2: begin ser_rx = ~ser_rx; step(1); end
         3: begin tick_pulse = 1; step(1); tick_pulse = 0; end
         default: begin rtc_alarm = 1; step(1); rtc_alarm = 0; end
      endcase
   endtask

   task automatic nmi(input int len);
      nmi_n = 0; step(len); nmi_n = 1; step(1);
   endtask

   // from clock wait with ien set, gie clear: continue to run
   task automatic wake_to_run(input string tag);
      clk_ready = 1; step(1); clk_ready = 0;
      chk(tag, ctl_state, ST_RUN);
   endtask

   // in transfer: finish it, then leave sleep through the non-maskable pin
   task automatic finish_xfer(input string tag);
      xfer_done = 1; step(1); xfer_done = 0;
      chk({tag, " back to sleep"}, ctl_state, ST_SLEEP);
      clk_ready = 1; nmi(3); step(1); clk_ready = 0;
      chk({tag, " nmi exit to run"}, ctl_state, ST_RUN);
   endtask

   task automatic trial(input int src, input int g, input int ie, input int xe, input int sp, input int cp);
      int exp;
      gie = g[0]; src_ien = ie[0] ? '1 : '0; src_xfer_en = xe[0] ? '1 : '0;
      for (int i = 0; i < NS; i++) src_prio[i*PW +: PW] = PW'(sp);
      clk_ready = 0;
      go_sleep(cp);
      chk("R2 sleep entry", ctl_state, ST_SLEEP);
      fire(src);
      chk("R7 wait after wake", ctl_state, ST_WAIT);
      step(2);
      chk("R7 held without clk_ready", ctl_state, ST_WAIT);
      chk("R7 cpu held", cpu_run, 0);
      clk_ready = 1; step(1);
      if (g == 1 && ie == 1 && xe == 1 && sp > cp) exp = ST_XFER;
      else if (ie == 0) exp = ST_IDLE;
      else exp = ST_RUN;
      chk("R8/R9/R10 continuation", ctl_state, exp);
      if (exp == ST_XFER) begin
         chk("R8 xfer_req pulse", xfer_req, 1);
         chk("R8 xfer_chan", xfer_chan, src);
         step(1);
         chk("R8 single pulse", xfer_req, 0);
         finish_xfer("R8");
      end else if (exp == ST_IDLE) begin
         chk("R9 no xfer_req", xfer_req, 0);
         idle_wake = 1; step(1); idle_wake = 0;
         chk("R9 idle to run", ctl_state, ST_RUN);
      end else begin
         chk("R10 no xfer_req", xfer_req, 0);
      end
      clk_ready = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      step(3); rst_n = 1; step(1);
      chk("R1 reset state", ctl_state, ST_RUN);
      chk("R1 reset cpu_run", cpu_run, 1);
      chk("R1 reset xfer_req", xfer_req, 0);

      // sweep of the continuation choice
      for (int s = 0; s < NS; s++)
         for (int c = 0; c < 8; c++)
            for (int sp = 0; sp < 4; sp++)
               for (int cp = 0; cp < 4; cp++)
                  trial(s, c & 1, (c >> 1) & 1, (c >> 2) & 1, sp, cp);

      // R3 edge fields on pin 0
      gie = 0; src_ien = '1; src_xfer_en = '0;
      ext_edge[1:0] = 2'b00; go_sleep(0);
      fire(0); chk("R3 field 00 ignores edges", ctl_state, ST_SLEEP);
      ext_pin[0] = 1; step(1); ext_edge[1:0] = 2'b01;
      ext_pin[0] = 0; step(1); chk("R3 rise-only ignores fall", ctl_state, ST_SLEEP);
      ext_edge[1:0] = 2'b10;
      ext_pin[0] = 1; step(1); chk("R3 fall-only ignores rise", ctl_state, ST_SLEEP);
      ext_pin[0] = 0; step(1); chk("R3 fall-only wakes on fall", ctl_state, ST_WAIT);
      wake_to_run("R3 return");
      ext_edge[1:0] = 2'b11; go_sleep(0);
      ext_pin[0] = 1; step(1); chk("R3 both: rise wakes", ctl_state, ST_WAIT);
      wake_to_run("R3 return");
      go_sleep(0);
      ext_pin[0] = 0; step(1); chk("R3 both: fall wakes", ctl_state, ST_WAIT);
      wake_to_run("R3 return");
      ext_edge[1:0] = 2'b01;

      // R4 serial alternate source
      ser_alt_en = 0; go_sleep(0);
      fire(2); chk("R4 line ignored when not selected", ctl_state, ST_SLEEP);
      ser_alt_en = 1;
      fire(2); chk("R4 selected line wakes", ctl_state, ST_WAIT);
      wake_to_run("R4 return");

      // R5 tick and alarm gating
      rtc_sleep_en = 0; go_sleep(0);
      fire(3); chk("R5 tick gated by sleep enable", ctl_state, ST_SLEEP);
      fire(4); chk("R5 alarm gated by sleep enable", ctl_state, ST_SLEEP);
      rtc_sleep_en = 1; tick_en = 0; rtc_en = 0;
      fire(3); chk("R5 tick gated by tick_en", ctl_state, ST_SLEEP);
      fire(4); chk("R5 alarm gated by rtc_en", ctl_state, ST_SLEEP);
      tick_en = 1;
      fire(3); chk("R5 tick wakes when enabled", ctl_state, ST_WAIT);
      wake_to_run("R5 return");
      rtc_en = 1; go_sleep(0);
      fire(4); chk("R5 alarm wakes when enabled", ctl_state, ST_WAIT);
      wake_to_run("R5 return");

      // R6 non-maskable filter and override
      gie = 0; src_ien = '0; go_sleep(0);
      nmi(1); step(2); chk("R6 spike rejected", ctl_state, ST_SLEEP);
      nmi(3); chk("R6 accepted pulse wakes", ctl_state, ST_WAIT);
      clk_ready = 1; step(1); clk_ready = 0;
      chk("R6 nmi goes to run despite enables", ctl_state, ST_RUN);
      gie = 1; src_ien = '1; src_xfer_en = '1;
      for (int i = 0; i < NS; i++) src_prio[i*PW +: PW] = 2'd3;
      go_sleep(0);
      nmi_n = 0; step(3); nmi_n = 1; tick_pulse = 1; step(1); tick_pulse = 0;
      chk("R6 nmi with tick wakes", ctl_state, ST_WAIT);
      clk_ready = 1; step(1); clk_ready = 0;
      chk("R6 nmi beats transfer source", ctl_state, ST_RUN);
      chk("R6 no transfer request", xfer_req, 0);

      // R11 arbitration
      src_prio = '0; src_prio[0*PW +: PW] = 2'd2; src_prio[3*PW +: PW] = 2'd1;
      go_sleep(0);
      ext_pin[0] = 1; tick_pulse = 1; step(1); ext_pin[0] = 0; tick_pulse = 0;
      clk_ready = 1; step(1);
      chk("R11 higher level wins state", ctl_state, ST_XFER);
      chk("R11 higher level wins chan", xfer_chan, 0);
      step(1); finish_xfer("R11");
      src_prio[3*PW +: PW] = 2'd2; src_prio[4*PW +: PW] = 2'd2;
      go_sleep(0);
      tick_pulse = 1; rtc_alarm = 1; step(1); tick_pulse = 0; rtc_alarm = 0;
      clk_ready = 1; step(1);
      chk("R11 tie goes to higher index", xfer_chan, 4);
      step(1); finish_xfer("R11 tie");

      // R12 stored CPU priority
      for (int i = 0; i < NS; i++) src_prio[i*PW +: PW] = 2'd1;
      go_sleep(2); cpu_prio = 0;
      fire(3); clk_ready = 1; step(1); clk_ready = 0;
      chk("R12 entry priority blocks transfer", ctl_state, ST_RUN);
      go_sleep(0); cpu_prio = 3;
      fire(3); clk_ready = 1; step(1);
      chk("R12 entry priority allows transfer", ctl_state, ST_XFER);
      step(1); finish_xfer("R12");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule